// File: doc/BRIEF.md
# Loadable Sum-of-Products Logic Array

This block is a small programmable logic array. A bank of product terms forms the AND plane. Each term is the AND of the literals that take part in it, one literal per input. The OR plane then forms each output as the OR of whichever terms are connected to it. Every output sees every term, so one term can feed any number of outputs. The default build has 3 inputs, 5 terms and 4 outputs.

The contents of both planes are held in registers and loaded one term row at a time through a word-wide configuration stream. A row carries two things: a two-bit literal code for each input, and a connection mask over the outputs. Once a load sequence is closed with a commit pulse, the outputs follow the inputs combinationally.

The configuration stream never applies back-pressure: `cfg_ready` is high in every cycle, and a word is taken on every clock edge where `cfg_valid` is high. Commit is a plain control pin.

Top module: `pla_array`

## Requirements
- R1: The literal code for input i sits in `cfg_lits[2i+1:2i]`. Code 2'b01 passes when the input is 1. Code 2'b10 passes when the input is 0. Code 2'b11 always passes (the input does not take part). Code 2'b00 never passes, which forces the whole term to 0.
- R2: A product term is the AND of its N_IN literal results. A term whose codes are all 2'b11 evaluates to 1.
- R3: Bit j of a row's `cfg_mask` connects that term to `dout[j]`. Each output is the OR of its connected terms, and an output with no connected terms is 0. One term may drive several outputs at once.
- R4: A word is accepted on a rising edge where `cfg_valid` is high. It replaces row `cfg_row` (both the literal codes and the mask) from that edge on. `cfg_ready` is always 1.
- R5: A word whose `cfg_row` is N_TERM or above is ignored. No row changes, and the hold state of R6 is not entered.
- R6: After an accepted in-range word, `dout` is 0 from that edge on. It stays 0 until an edge where `cfg_commit` is high. If commit and a word arrive on the same edge, the word is stored and the outputs are live after that edge.
- R7: Synchronous active-high `rst` sets every literal code to 2'b00 and every mask to 0, and leaves the block not holding. As a result `dout` is 0 for every input.
- R8: While not holding, `dout` is a purely combinational function of `din` and the stored rows. There is no clock delay from `din`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_valid | input | 1 | Configuration word present |
| cfg_ready | output | 1 | Configuration word accepted (always 1) |
| cfg_row | input | ROW_W | Term row to write |
| cfg_lits | input | 2*N_IN | Literal codes, two bits per input |
| cfg_mask | input | N_OUT | Output connection mask of the row |
| cfg_commit | input | 1 | Ends a load and releases the outputs |
| din | input | N_IN | Logic inputs |
| dout | output | N_OUT | Logic outputs |

## Verification
The main test loads a five-term personality, with A, B and C on `din[0]`, `din[1]` and `din[2]`:

- AB feeds F1 and F2.
- B'C feeds F3.
- AC' feeds F1.
- B'C' feeds F0 and F2.
- A feeds F0 and F3.

All eight input combinations are then walked against the expected sums. Because terms are shared, a wrongly connected mask column or a swapped literal polarity shows up in specific rows of this walk.

Directed cases cover the corner cases one by one:

- A term forced off with code 00, which differs from a don't-care term that is always true.
- Terms that are true but have no connections, which must still give 0 outputs.
- An out-of-range row write, whose acceptance would turn an all-zero row of the truth table into all ones.
- The hold-then-commit sequence, including a write and a commit on the same edge.

// File: rtl/pla_pkg.sv
package pla_pkg;
  typedef enum logic [1:0] {
    LIT_OFF  = 2'b00,
    LIT_TRUE = 2'b01,
    LIT_COMP = 2'b10,
    LIT_ANY  = 2'b11
  } lit_e;

  // One literal: code bit 0 lets a high input pass, bit 1 lets a low input pass.
  function automatic logic lit_pass(input logic x, input logic [1:0] code);
    return x ? code[0] : code[1];
  endfunction
endpackage

// File: rtl/pla_row_store.sv
module pla_row_store #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 5,
  parameter int N_OUT  = 4,
  parameter int ROW_W  = 3
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic [ROW_W-1:0]                    wr_row,
  input  logic [2*N_IN-1:0]                   wr_lits,
  input  logic [N_OUT-1:0]                    wr_mask,
  output logic [N_TERM-1:0][2*N_IN-1:0]       lits_q,
  output logic [N_TERM-1:0][N_OUT-1:0]        mask_q
);
  for (genvar t = 0; t < N_TERM; t++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst) begin
        lits_q[t] <= '0;
        mask_q[t] <= '0;
      end else if (wr_en && (wr_row == ROW_W'(t))) begin
        lits_q[t] <= wr_lits;
        mask_q[t] <= wr_mask;
      end
    end
  end
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int N_TERM = 5
) (
  input  logic [N_IN-1:0]                    din,
  input  logic [N_TERM-1:0][2*N_IN-1:0]      lits,
  output logic [N_TERM-1:0]                  term
);
  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    always_comb begin
      term[t] = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
        term[t] = term[t] & lit_pass(din[i], lits[t][2*i +: 2]);
      end
    end
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 5,
  parameter int N_OUT  = 4
) (
  input  logic [N_TERM-1:0]              term,
  input  logic [N_TERM-1:0][N_OUT-1:0]   mask,
  output logic [N_OUT-1:0]               sum
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [N_TERM-1:0] column;
    for (genvar t = 0; t < N_TERM; t++) begin : g_col
      assign column[t] = mask[t][o];
    end
    assign sum[o] = |(term & column);
  end
endmodule

// File: rtl/pla_array.sv
module pla_array #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 5,
  parameter int N_OUT  = 4,
  localparam int ROW_W = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_valid,
  output logic                 cfg_ready,
  input  logic [ROW_W-1:0]     cfg_row,
  input  logic [2*N_IN-1:0]    cfg_lits,
  input  logic [N_OUT-1:0]     cfg_mask,
  input  logic                 cfg_commit,
  input  logic [N_IN-1:0]      din,
  output logic [N_OUT-1:0]     dout
);
  localparam logic [ROW_W:0] ROW_LIM = N_TERM[ROW_W:0];

  logic                                wr_hit;
  logic                                holding_q;
  logic [N_TERM-1:0][2*N_IN-1:0]       lits_q;
  logic [N_TERM-1:0][N_OUT-1:0]        mask_q;
  logic [N_TERM-1:0]                   term;
  logic [N_OUT-1:0]                    sum;

  assign cfg_ready = 1'b1;
  assign wr_hit    = cfg_valid && cfg_ready && ({1'b0, cfg_row} < ROW_LIM);

  always_ff @(posedge clk) begin
    if (rst)             holding_q <= 1'b0;
    else if (cfg_commit) holding_q <= 1'b0;
    else if (wr_hit)     holding_q <= 1'b1;
  end

  pla_row_store #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .ROW_W(ROW_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_hit), .wr_row(cfg_row),
    .wr_lits(cfg_lits), .wr_mask(cfg_mask), .lits_q(lits_q), .mask_q(mask_q)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .din(din), .lits(lits_q), .term(term)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .term(term), .mask(mask_q), .sum(sum)
  );

  assign dout = holding_q ? '0 : sum;
endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 5,
  parameter int N_OUT  = 4,
  parameter int ROW_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_valid,
  input logic [ROW_W-1:0]  cfg_row,
  input logic              cfg_commit,
  input logic [N_IN-1:0]   din,
  input logic [N_OUT-1:0]  dout
);
  localparam logic [ROW_W:0] ROW_LIM = N_TERM[ROW_W:0];

  // R6: an in-range word without commit puts the outputs on hold
  p_hold_after_write_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && ({1'b0, cfg_row} < ROW_LIM) && !cfg_commit) |=> (dout == '0));

  // R7: first cycle after reset shows the cleared array
  p_reset_clear_r7: assert property (@(posedge clk)
    $fell(rst) |-> (dout == '0));

  // R5: an out-of-range word leaves the outputs alone while inputs hold
  p_ignore_range_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && !({1'b0, cfg_row} < ROW_LIM) && !cfg_commit) ##1 $stable(din)
      |-> $stable(dout));

  // R8: with no configuration traffic the outputs depend on din only
  p_comb_only_r8: assert property (@(posedge clk) disable iff (rst)
    (!cfg_valid && !cfg_commit) ##1 $stable(din) |-> $stable(dout));
endmodule

bind pla_array pla_array_chk #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_row(cfg_row),
  .cfg_commit(cfg_commit), .din(din), .dout(dout)
);

// File: tb/pla_array_tb.sv
module pla_array_tb;
  localparam int CLK_P = 10;
  localparam int NI = 3, NT = 5, NO = 4, RW = 3;

  // {din, expected dout} for the shared-term personality, A=din[0] B=din[1] C=din[2]
  localparam logic [6:0] VEC [8] = '{
    {3'b000, 4'b0101}, {3'b001, 4'b1111}, {3'b010, 4'b0000}, {3'b011, 4'b1111},
    {3'b100, 4'b1000}, {3'b101, 4'b1001}, {3'b110, 4'b0000}, {3'b111, 4'b1111}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_valid = 1'b0, cfg_commit = 1'b0;
  logic cfg_ready;
  logic [RW-1:0] cfg_row = '0;
  logic [2*NI-1:0] cfg_lits = '0;
  logic [NO-1:0] cfg_mask = '0;
  logic [NI-1:0] din = '0;
  logic [NO-1:0] dout;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pla_array #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO)) u_dut (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_row(cfg_row), .cfg_lits(cfg_lits), .cfg_mask(cfg_mask),
    .cfg_commit(cfg_commit), .din(din), .dout(dout)
  );

  task automatic check(input logic [NO-1:0] got, input logic [NO-1:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // drive one word for one edge, optionally with commit on the same edge
  task automatic put_row(input int row, input logic [2*NI-1:0] lits,
                         input logic [NO-1:0] mask, input bit with_commit);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_row = RW'(row); cfg_lits = lits; cfg_mask = mask;
    cfg_commit = with_commit;
    @(negedge clk);
    cfg_valid = 1'b0; cfg_commit = 1'b0;
  endtask

  task automatic commit();
    @(negedge clk);
    cfg_commit = 1'b1;
    @(negedge clk);
    cfg_commit = 1'b0;
  endtask

  task automatic apply(input logic [NI-1:0] v);
    din = v;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R7: cleared array gives 0 for every input
    for (int v = 0; v < 8; v++) begin
      apply(NI'(v));
      check(dout, 4'b0000, "R7 reset state");
    end
    total++;
    if (cfg_ready !== 1'b1) begin
      bad++;
      $display("FAIL R4 ready: got %b expected 1", cfg_ready);
    end

    // load the personality: literal codes {C,B,A}
    apply(3'b001);
    put_row(0, 6'b11_01_01, 4'b0110, 1'b0);  // AB
    check(dout, 4'b0000, "R6 hold after write");
    put_row(1, 6'b01_10_11, 4'b1000, 1'b0);  // B'C
    put_row(2, 6'b10_11_01, 4'b0010, 1'b0);  // AC'
    put_row(3, 6'b10_10_11, 4'b0101, 1'b0);  // B'C'
    put_row(4, 6'b11_11_01, 4'b1001, 1'b0);  // A
    check(dout, 4'b0000, "R6 still held before commit");
    commit();

    // R1 R2 R3 R8: walk the truth table
    for (int k = 0; k < 8; k++) begin
      apply(VEC[k][6:4]);
      check(dout, VEC[k][3:0], $sformatf("R3 truth row din=%b", VEC[k][6:4]));
    end

    // R5: out-of-range row with an always-true, all-connected term
    apply(3'b010);
    put_row(7, 6'b11_11_11, 4'b1111, 1'b0);
    check(dout, 4'b0000, "R5 out-of-range ignored");
    put_row(5, 6'b11_11_11, 4'b1111, 1'b0);
    apply(3'b001);
    check(dout, 4'b1111, "R5 no hold entered");

    // R1: code 00 forces term A off; F0=B'C'=1 F1=1 F2=1 F3=B'C=0
    put_row(4, 6'b11_11_00, 4'b1001, 1'b1);  // R6 write+commit same edge
    check(dout, 4'b0111, "R1 code 00 forces term off / R6 same-edge commit");

    // R2: all-don't-care term on F0 only
    put_row(4, 6'b11_11_11, 4'b0001, 1'b1);
    apply(3'b010);
    check(dout, 4'b0001, "R2 all don't-care term is 1");

    // R3: true terms without connections give 0
    for (int t = 0; t < NT; t++) put_row(t, 6'b11_11_11, 4'b0000, 1'b0);
    commit();
    apply(3'b101);
    check(dout, 4'b0000, "R3 unconnected output is 0");

    // R4: single row rewrite takes effect after its edge
    put_row(2, 6'b01_11_11, 4'b1010, 1'b1);  // C feeds F1 and F3
    check(dout, 4'b1010, "R4 row write effective");
    apply(3'b011);
    check(dout, 4'b0000, "R8 follows din without clock");

    // R7: reset mid-operation clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    apply(3'b101);
    check(dout, 4'b0000, "R7 reset clears rows");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule